// File: doc/BRIEF.md
# GPIO Input-Change Interrupt Controller

This block watches the input pins of one or two GPIO channels and raises a single interrupt when any of them moves. Every input bit is registered on each clock; a channel whose current sample differs from the one before in any bit records an event in its own status bit. The events are gated by a per-channel mask and by a global master switch, and the result drives one active-high, level-sensitive interrupt line.

Software reaches three 32-bit registers through a plain single-cycle register port. There is no back-pressure: a write is taken on the clock edge where `reg_wr` is high, and `reg_rdata` follows `reg_addr` combinationally, so any register decode can sit in front of the block. Status bits toggle when written with 1. An interrupt handler can therefore clear a pending event, and a test can force one, without a read-modify-write.

Top module: `gpio_chg_irq`

## Requirements
- R1: After a synchronous active-low reset, `irq_o` is 0 and the master switch, mask and status registers all read 0.
- R2: The master switch lives at byte offset 0x11C in bit 31 and is written from `reg_wdata[31]`. Bits 30..0 of that word read 0.
- R3: The channel mask lives at offset 0x128: bit 0 for channel 1 and bit 1 for channel 2. Bits 31..2 read 0.
- R4: A rise or fall on any input bit of a channel sets that channel's status bit (offset 0x120, same bit order as R3). The bit reads 1 after the second rising clock edge following the input change and not after the first. An input that changes while reset is held gives no event.
- R5: A write to 0x120 inverts each status bit whose `reg_wdata` bit is 1 and leaves unchanged each status bit whose `reg_wdata` bit is 0. This can both clear and set a status bit.
- R6: When an input event and an inverting write hit the same status bit in the same cycle, the bit ends up 1.
- R7: `irq_o` is 1 exactly when the master switch is 1 and some channel has both its status bit and its mask bit at 1.
- R8: Status bits keep recording events while the mask or the master switch is off. Turning them on later raises `irq_o` for an event already pending.
- R9: With `DUAL_CH` = 0, bit 1 of the mask and status registers always reads 0, whether channel 2 inputs move or software writes it.
- R10: Offsets other than 0x11C, 0x120 and 0x128 read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for sampling and registers |
| rst_n | input | 1 | Synchronous reset, active low |
| ch1_in | input | CH1_W | Channel 1 input pins |
| ch2_in | input | CH2_W | Channel 2 input pins (ignored when `DUAL_CH` = 0) |
| reg_wr | input | 1 | Write strobe, taken on the rising edge |
| reg_addr | input | 12 | Byte offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq_o | output | 1 | Level interrupt, active high |

## Verification
Embedded properties check, on every cycle, the rules that tie one clock to the next. An edge flag follows a real change in the sampled pins. An edge flag always leaves the status bit set. A 1 written to a status bit with no competing event flips that bit. Status, mask and master switch hold their values when neither a write nor an event touches them. An absent second channel stays zero. Only the directed scenarios can show the end-to-end results at the pins. These cover the exact two-edge latency from pin to status, reset-time input movement giving no event, the event-wins collision, the gating combinations of `irq_o`, a pending event raised late by enabling, and the inert unmapped offsets.

// File: rtl/gci_pkg.sv
package gci_pkg;
  localparam int unsigned ADDR_W  = 12;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned NUM_CH  = 2;
  localparam logic [ADDR_W-1:0] OFS_MASTER = 12'h11C;
  localparam logic [ADDR_W-1:0] OFS_STATUS = 12'h120;
  localparam logic [ADDR_W-1:0] OFS_MASK   = 12'h128;
  localparam int unsigned MASTER_BIT = 31;
endpackage

// File: rtl/gci_edge_det.sv
module gci_edge_det #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pins_i,
  output logic         chg_o
);
  logic [W-1:0] cur_q;
  logic [W-1:0] old_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_q <= pins_i;
      old_q <= pins_i;
    end else begin
      cur_q <= pins_i;
      old_q <= cur_q;
    end
  end

  assign chg_o = |(cur_q ^ old_q);

  // R4: first cycle out of reset never shows a change
  p_quiet_after_reset_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !chg_o);
  // R4: a change flag needs a real difference between two pin samples
  p_chg_has_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    chg_o |-> ($past(pins_i) != $past(pins_i, 2)));
endmodule

// File: rtl/gci_ctrl_regs.sv
module gci_ctrl_regs
  import gci_pkg::*;
#(
  parameter bit DUAL_CH = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [NUM_CH-1:0] evt_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  localparam logic [NUM_CH-1:0] CH_MASK = DUAL_CH ? 2'b11 : 2'b01;

  logic              master_q;
  logic [NUM_CH-1:0] mask_q;
  logic [NUM_CH-1:0] stat_q;
  logic [NUM_CH-1:0] flip;
  logic [NUM_CH-1:0] evt_m;
  logic              hit_master, hit_mask, hit_stat;
  logic              unused_wdata;

  assign hit_master = wr_i && (addr_i == OFS_MASTER);
  assign hit_mask   = wr_i && (addr_i == OFS_MASK);
  assign hit_stat   = wr_i && (addr_i == OFS_STATUS);
  assign flip       = hit_stat ? (wdata_i[NUM_CH-1:0] & CH_MASK) : '0;
  assign evt_m      = evt_i & CH_MASK;
  assign unused_wdata = ^wdata_i[MASTER_BIT-1:NUM_CH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      master_q <= 1'b0;
      mask_q   <= '0;
      stat_q   <= '0;
    end else begin
      if (hit_master) master_q <= wdata_i[MASTER_BIT];
      if (hit_mask)   mask_q   <= wdata_i[NUM_CH-1:0] & CH_MASK;
      stat_q <= (stat_q ^ flip) | evt_m;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      OFS_MASTER: rdata_o[MASTER_BIT]   = master_q;
      OFS_MASK:   rdata_o[NUM_CH-1:0]   = mask_q;
      OFS_STATUS: rdata_o[NUM_CH-1:0]   = stat_q;
      default:    rdata_o = '0;
    endcase
  end

  assign irq_o = master_q & |(stat_q & mask_q);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    if (CH_MASK[c]) begin : g_live
      // R4: an event always leaves the status bit set
      p_evt_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i[c] |=> stat_q[c]);
      // R5: a 1 written with no competing event flips the bit
      p_flip_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_stat && wdata_i[c] && !evt_i[c]) |=> (stat_q[c] != $past(stat_q[c])));
    end else begin : g_dead
      // R9: absent channel keeps zero state
      p_absent_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q[c] == 1'b0) && (mask_q[c] == 1'b0));
    end
  end

  // R5: no write and no event leaves status unchanged
  p_stat_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit_stat && (evt_i == '0)) |=> $stable(stat_q));
  // R2: master switch only moves on its own write
  p_master_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_master |=> $stable(master_q));
  // R3: mask only moves on its own write
  p_mask_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_mask |=> $stable(mask_q));
endmodule

// File: rtl/gpio_chg_irq.sv
module gpio_chg_irq
  import gci_pkg::*;
#(
  parameter int unsigned CH1_W   = 8,
  parameter int unsigned CH2_W   = 4,
  parameter bit          DUAL_CH = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CH1_W-1:0]  ch1_in,
  input  logic [CH2_W-1:0]  ch2_in,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_o
);
  logic [NUM_CH-1:0] evt;

  gci_edge_det #(.W(CH1_W)) u_det1 (
    .clk(clk), .rst_n(rst_n), .pins_i(ch1_in), .chg_o(evt[0])
  );

  gci_edge_det #(.W(CH2_W)) u_det2 (
    .clk(clk), .rst_n(rst_n), .pins_i(ch2_in), .chg_o(evt[1])
  );

  gci_ctrl_regs #(.DUAL_CH(DUAL_CH)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_i(reg_wr), .addr_i(reg_addr),
    .wdata_i(reg_wdata), .evt_i(evt), .rdata_o(reg_rdata), .irq_o(irq_o)
  );
endmodule

// File: tb/gpio_chg_irq_tb_top.sv
module gpio_chg_irq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  ch1 = '0;
  logic [3:0]  ch2 = '0;
  logic        wr = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, rdata_s;
  logic        irq, irq_s;
  int n_chk = 0;
  int n_fail = 0;

  localparam logic [11:0] A_MST = 12'h11C;
  localparam logic [11:0] A_STA = 12'h120;
  localparam logic [11:0] A_MSK = 12'h128;

  always #2 clk = ~clk;

  gpio_chg_irq #(.CH1_W(8), .CH2_W(4), .DUAL_CH(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .ch1_in(ch1), .ch2_in(ch2), .reg_wr(wr),
    .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata), .irq_o(irq));

  gpio_chg_irq #(.CH1_W(8), .CH2_W(4), .DUAL_CH(1'b0)) dut_s_i (
    .clk(clk), .rst_n(rst_n), .ch1_in(ch1), .ch2_in(ch2), .reg_wr(wr),
    .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata_s), .irq_o(irq_s));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; wr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wreg(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rreg(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); wr = 1'b0; addr = a; #1; d = rdata;
  endtask

  task automatic expect_reg(input string req, input logic [11:0] a, input logic [31:0] e);
    logic [31:0] d;
    rreg(a, d);
    chk(req, d, e);
  endtask

  task automatic t_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); ch1 = ch1 ^ 8'h81; ch2 = ch2 ^ 4'h3;
    @(negedge clk); rst_n = 1'b1;
    chk("R1 irq after reset", {31'b0, irq}, 32'h0);
    expect_reg("R1 master reset", A_MST, 32'h0);
    expect_reg("R1 mask reset", A_MSK, 32'h0);
    repeat (3) @(negedge clk);
    expect_reg("R4 no event from reset-time input move", A_STA, 32'h0);
  endtask

  task automatic t_master();
    wreg(A_MST, 32'hFFFF_FFFF);
    expect_reg("R2 master bit31 only", A_MST, 32'h8000_0000);
    wreg(A_MST, 32'h7FFF_FFFF);
    expect_reg("R2 master cleared by bit31=0", A_MST, 32'h0);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    wreg(A_MSK, 32'hFFFF_FFFF);
    rreg(A_MSK, d);
    chk("R3 mask two bits", d, 32'h3);
    chk("R9 single-channel mask bit1 zero", rdata_s, 32'h1);
    wreg(A_MSK, 32'h0);
    expect_reg("R3 mask cleared", A_MSK, 32'h0);
  endtask

  task automatic edge_probe(input string req, input logic [7:0] f1, input logic [3:0] f2,
                            input logic [31:0] exp);
    @(negedge clk); addr = A_STA; ch1 = ch1 ^ f1; ch2 = ch2 ^ f2;
    @(negedge clk); #1;
    chk({req, " not after one edge"}, rdata, 32'h0);
    @(negedge clk); #1;
    chk({req, " after two edges"}, rdata, exp);
    wreg(A_STA, exp);
    expect_reg({req, " cleared"}, A_STA, 32'h0);
  endtask

  task automatic t_edges();
    edge_probe("R4 ch1 rise", 8'h08, 4'h0, 32'h1);
    edge_probe("R4 ch1 fall", 8'h08, 4'h0, 32'h1);
    edge_probe("R4 ch2 two bits", 8'h00, 4'h6, 32'h2);
    edge_probe("R4 both channels", 8'h40, 4'h1, 32'h3);
  endtask

  task automatic t_tow();
    wreg(A_STA, 32'h1);
    expect_reg("R5 write1 sets", A_STA, 32'h1);
    wreg(A_STA, 32'h0);
    expect_reg("R5 write0 no change", A_STA, 32'h1);
    wreg(A_STA, 32'h3);
    expect_reg("R5 write11 flips both", A_STA, 32'h2);
    wreg(A_STA, 32'h2);
    expect_reg("R5 write clears", A_STA, 32'h0);
  endtask

  task automatic t_collide();
    wreg(A_STA, 32'h1);
    @(negedge clk); ch1 = ch1 ^ 8'h02;
    @(negedge clk); wr = 1'b1; addr = A_STA; wdata = 32'h1;
    @(negedge clk); wr = 1'b0;
    expect_reg("R6 event wins over flip", A_STA, 32'h1);
    wreg(A_STA, 32'h1);
  endtask

  task automatic t_gate();
    wreg(A_STA, 32'h1);
    #1 chk("R7 irq off, nothing enabled", {31'b0, irq}, 32'h0);
    wreg(A_MSK, 32'h1);
    #1 chk("R7 irq off, master off", {31'b0, irq}, 32'h0);
    wreg(A_MST, 32'h8000_0000);
    #1 chk("R7 irq on", {31'b0, irq}, 32'h1);
    wreg(A_MSK, 32'h2);
    #1 chk("R7 irq off, other channel masked in", {31'b0, irq}, 32'h0);
    wreg(A_MSK, 32'h3);
    #1 chk("R7 irq back on", {31'b0, irq}, 32'h1);
    wreg(A_STA, 32'h1);
    #1 chk("R7 irq off after clear", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_pending();
    @(negedge clk); ch2 = ch2 ^ 4'h8;
    repeat (3) @(negedge clk);
    expect_reg("R8 recorded while disabled", A_STA, 32'h2);
    #1 chk("R8 irq off while disabled", {31'b0, irq}, 32'h0);
    wreg(A_MSK, 32'h2);
    wreg(A_MST, 32'h8000_0000);
    #1 chk("R8 late enable raises irq", {31'b0, irq}, 32'h1);
  endtask

  task automatic t_single();
    logic [31:0] d;
    @(negedge clk); ch2 = ch2 ^ 4'h1;
    repeat (3) @(negedge clk);
    wreg(A_STA, 32'h2);
    rreg(A_STA, d);
    chk("R9 single-channel status stays zero", rdata_s, 32'h0);
    wreg(A_STA, 32'h3);
    rreg(A_STA, d);
    chk("R9 single-channel only bit0 flips", rdata_s, 32'h1);
  endtask

  task automatic t_unmapped();
    wreg(12'h124, 32'hFFFF_FFFF);
    wreg(12'h000, 32'hFFFF_FFFF);
    wreg(12'h12C, 32'hFFFF_FFFF);
    expect_reg("R10 unmapped reads zero", 12'h124, 32'h0);
    expect_reg("R10 unmapped reads zero", 12'h000, 32'h0);
    expect_reg("R10 master untouched", A_MST, 32'h0);
    expect_reg("R10 mask untouched", A_MSK, 32'h0);
    expect_reg("R10 status untouched", A_STA, 32'h0);
    #1 chk("R10 irq untouched", {31'b0, irq}, 32'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    do_reset(); t_master();
    do_reset(); t_mask();
    do_reset(); t_edges();
    do_reset(); t_tow();
    do_reset(); t_collide();
    do_reset(); t_gate();
    do_reset(); t_pending();
    do_reset(); t_single();
    do_reset(); t_unmapped();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule